// File: doc/BRIEF.md
# Host-to-Core Width-Converting Receive FIFO

This block buffers data written by a 32-bit host bus until a 24-bit processor core collects it. There are two packing modes. In narrow packing the storage holds 24-bit words, six deep, and each host word gives up its low 24 bits. In wide packing the storage holds whole 32-bit words, three deep. The core then reads each word in two pieces: the low 16 bits first, then the high 16 bits, each right-aligned in the 24-bit result with the top byte zero. An entry is released only after its second piece has been read.

The host side works in one of two roles. As a bus master, every data word that comes back from the remote target is pushed with no address check. As a bus target, a write is stored only when its byte offset from the block's base address lies inside a fixed window. The role and the format code of the selected role choose the packing mode. Any change of the chosen packing mode empties the storage.

Top module: `h2c_wfifo`

## Requirements
- R1: Narrow packing (master role with a non-zero master format code) stores host_wdata[23:0], holds exactly six entries, and returns them to the core in write order.
- R2: Wide packing is chosen by the master role with master format code 0, or by the target role with target format code 0; wide packing holds exactly three entries. The target role with a non-zero target format code uses narrow packing.
- R3: In wide packing the first core read of an entry returns {8'h00, word[15:0]} and the second returns {8'h00, word[31:16]}; the entry is released only by the second read.
- R4: In the target role a host write is stored only if host_addr is between 16'h001C and 16'hFFFC inclusive; a write outside that range changes nothing.
- R5: In the master role every host write offered while host_ready is high is stored, whatever host_addr holds.
- R6: When the storage is full, fifo_full is high and host_ready is low, and a host write in that state is dropped without changing the stored data.
- R7: When the storage is empty, fifo_empty is high, core_valid is low, and core_rd has no effect.
- R8: A host write and a core read in the same cycle both take effect, including a read that finishes a half-consumed wide entry.
- R9: In a cycle where the chosen packing mode differs from that of the previous cycle, host_ready and core_valid are low, and at the next edge the storage empties and the next wide read starts on the low half.
- R10: While rst_n is low at a clock edge the storage empties and the half select returns to the low half.
- R11: Only the format code of the selected role has an effect: fmt_target is ignored in the master role and fmt_master is ignored in the target role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_sel | input | 1 | 1 = master role, 0 = target role |
| fmt_master | input | 2 | Format code used in the master role |
| fmt_target | input | 2 | Format code used in the target role |
| host_valid | input | 1 | Host offers a write this cycle |
| host_addr | input | 16 | Byte offset of the write from the base address (target role) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Storage can accept a write this cycle |
| core_rd | input | 1 | Core consumes the current word |
| core_data | output | 24 | Word offered to the core |
| core_valid | output | 1 | core_data holds a word |
| fifo_full | output | 1 | Storage is at the depth of the current mode |
| fifo_empty | output | 1 | Storage holds no entry |

## Verification
A host push and a core pop can land on the same edge, and the delicate case is a pop that releases a wide entry whose low half has already been read. The bench loads one wide word, reads its low half, then in a single cycle offers a new host word while reading the high half; it then expects the new word's low half to be on core_data with the storage holding one entry, judged by how many further pushes fit before fifo_full rises. A push and a pop on empty storage in one cycle are also driven, and the pop must be ignored while the push is kept.

// File: rtl/h2c_pkg.sv
package h2c_pkg;

   typedef enum logic {
      PK_NARROW = 1'b0,
      PK_WIDE   = 1'b1
   } pack_e;

   // The packing follows the format code of the active bus role only.
   function automatic pack_e pick_pack(input logic       master,
                                       input logic [1:0] fmt_m,
                                       input logic [1:0] fmt_t);
      logic [1:0] code;
      code = master ? fmt_m : fmt_t;
      return (code == 2'd0) ? PK_WIDE : PK_NARROW;
   endfunction

endpackage

// File: rtl/h2c_win_decode.sv
module h2c_win_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned WIN_LO = 'h001C,
   parameter int unsigned WIN_HI = 'hFFFC
) (
   input  logic              master,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(WIN_LO);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(WIN_HI);

   if (WIN_LO > WIN_HI) begin : g_bad_win
      $error("h2c_win_decode: window low bound above high bound");
   end

   always_comb begin
      hit = master || ((addr >= LO_A) && (addr <= HI_A));
   end

endmodule

// File: rtl/h2c_store.sv
module h2c_store #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DEPTH_NR = 6,
   parameter int unsigned DEPTH_WD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wide,
   input  logic              push,
   input  logic              pop,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] head,
   output logic              full,
   output logic              empty
);

   localparam int unsigned DMAX = (DEPTH_NR > DEPTH_WD) ? DEPTH_NR : DEPTH_WD;
   localparam int unsigned PW   = (DMAX > 1) ? $clog2(DMAX) : 1;
   localparam int unsigned CW   = $clog2(DMAX + 1);
   localparam logic [CW-1:0] CAP_NR = CW'(DEPTH_NR);
   localparam logic [CW-1:0] CAP_WD = CW'(DEPTH_WD);

   logic [WORD_W-1:0] mem [DMAX];
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     count;
   logic [CW-1:0]     cap;
   logic              do_push, do_pop;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p,
                                          input logic [CW-1:0] lim);
      return (CW'(p) == lim - CW'(1)) ? '0 : p + PW'(1);
   endfunction

   always_comb begin
      cap     = wide ? CAP_WD : CAP_NR;
      full    = (count == cap);
      empty   = (count == '0);
      do_push = push && !full && !flush;
      do_pop  = pop && !empty && !flush;
      head    = mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr, cap);
         if (do_pop)  rd_ptr <= bump(rd_ptr, cap);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/h2c_unpack.sv
module h2c_unpack #(
   parameter int unsigned HOST_W = 32,
   parameter int unsigned CORE_W = 24,
   parameter int unsigned HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wide,
   input  logic              avail,
   input  logic              core_rd,
   input  logic [HOST_W-1:0] head,
   output logic [CORE_W-1:0] core_data,
   output logic              core_valid,
   output logic              pop_entry
);

   logic              upper;
   logic              take;
   logic [CORE_W-1:0] narrow_word;
   logic [CORE_W-1:0] wide_word;
   logic [HALF_W-1:0] piece;

   if (CORE_W <= HOST_W) begin : g_nr_slice
      assign narrow_word = head[CORE_W-1:0];
   end else begin : g_nr_pad
      assign narrow_word = {{(CORE_W-HOST_W){1'b0}}, head};
   end

   if (CORE_W > HALF_W) begin : g_wd_pad
      assign wide_word = {{(CORE_W-HALF_W){1'b0}}, piece};
   end else begin : g_wd_fit
      assign wide_word = piece;
   end

   always_comb begin
      piece      = upper ? head[HOST_W-1:HALF_W] : head[HALF_W-1:0];
      core_valid = avail && !flush;
      take       = core_rd && core_valid;
      pop_entry  = take && (!wide || upper);
      core_data  = wide ? wide_word : narrow_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         upper <= 1'b0;
      end else if (take && wide) begin
         upper <= !upper;
      end
   end

endmodule

// File: rtl/h2c_wfifo.sv
module h2c_wfifo
   import h2c_pkg::*;
#(
   parameter int unsigned HOST_W   = 32,
   parameter int unsigned CORE_W   = 24,
   parameter int unsigned HALF_W   = 16,
   parameter int unsigned DEPTH_NR = 6,
   parameter int unsigned DEPTH_WD = 3,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned WIN_LO   = 'h001C,
   parameter int unsigned WIN_HI   = 'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic [1:0]        fmt_master,
   input  logic [1:0]        fmt_target,
   input  logic              host_valid,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic              host_ready,
   input  logic              core_rd,
   output logic [CORE_W-1:0] core_data,
   output logic              core_valid,
   output logic              fifo_full,
   output logic              fifo_empty
);

   if (HALF_W * 2 != HOST_W) begin : g_bad_half
      $error("h2c_wfifo: HALF_W must be half of HOST_W");
   end
   if (CORE_W < HALF_W) begin : g_bad_core
      $error("h2c_wfifo: CORE_W must hold a half word");
   end
   if (DEPTH_NR < 2 || DEPTH_WD < 2) begin : g_bad_depth
      $error("h2c_wfifo: depths must be at least two");
   end

   pack_e pack_now, pack_q;
   logic  wide, flush, hit, push, pop_entry, full_i, empty_i;
   logic [HOST_W-1:0] head;

   always_comb begin
      pack_now   = pick_pack(master_sel, fmt_master, fmt_target);
      wide       = (pack_now == PK_WIDE);
      flush      = (pack_now != pack_q);
      host_ready = !full_i && !flush;
      push       = host_valid && host_ready && hit;
      fifo_full  = full_i;
      fifo_empty = empty_i;
   end

   always_ff @(posedge clk) begin
      pack_q <= pack_now;
   end

   h2c_win_decode #(
      .ADDR_W (ADDR_W),
      .WIN_LO (WIN_LO),
      .WIN_HI (WIN_HI)
   ) u_dec (
      .master (master_sel),
      .addr   (host_addr),
      .hit    (hit)
   );

   h2c_store #(
      .WORD_W   (HOST_W),
      .DEPTH_NR (DEPTH_NR),
      .DEPTH_WD (DEPTH_WD)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .wide  (wide),
      .push  (push),
      .pop   (pop_entry),
      .wdata (host_wdata),
      .head  (head),
      .full  (full_i),
      .empty (empty_i)
   );

   h2c_unpack #(
      .HOST_W (HOST_W),
      .CORE_W (CORE_W),
      .HALF_W (HALF_W)
   ) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .wide       (wide),
      .avail      (!empty_i),
      .core_rd    (core_rd),
      .head       (head),
      .core_data  (core_data),
      .core_valid (core_valid),
      .pop_entry  (pop_entry)
   );

endmodule

// File: rtl/h2c_wfifo_chk.sv
module h2c_wfifo_chk #(
   parameter int unsigned CORE_W = 24,
   parameter int unsigned HALF_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_sel,
   input logic [1:0]        fmt_master,
   input logic [1:0]        fmt_target,
   input logic              host_ready,
   input logic              core_rd,
   input logic [CORE_W-1:0] core_data,
   input logic              core_valid,
   input logic              fifo_full,
   input logic              fifo_empty
);

   logic wide_obs, wide_prev;

   always_comb begin
      wide_obs = master_sel ? (fmt_master == 2'd0) : (fmt_target == 2'd0);
   end

   always_ff @(posedge clk) begin
      wide_prev <= wide_obs;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !host_ready);                                        // R6

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !core_valid);                                       // R7

   AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));                                       // R1

   AST_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid && wide_obs) |-> (core_data[CORE_W-1:HALF_W] == '0));  // R3

   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_obs != wide_prev) |=> fifo_empty);                           // R9

   AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_obs != wide_prev) |-> (!host_ready && !core_valid));         // R9

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (core_valid && !core_rd && (wide_obs == wide_prev))
         |=> (!core_valid || $stable(core_data)));                       // R1

endmodule

bind h2c_wfifo h2c_wfifo_chk #(
   .CORE_W (CORE_W),
   .HALF_W (HALF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .master_sel (master_sel),
   .fmt_master (fmt_master),
   .fmt_target (fmt_target),
   .host_ready (host_ready),
   .core_rd    (core_rd),
   .core_data  (core_data),
   .core_valid (core_valid),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty)
);

// File: tb/h2c_wfifo_bench.sv
module h2c_wfifo_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_sel = 1'b1;
   logic [1:0]  fmt_master = 2'd1;
   logic [1:0]  fmt_target = 2'd0;
   logic        host_valid = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ready;
   logic        core_rd = 1'b0;
   logic [23:0] core_data;
   logic        core_valid;
   logic        fifo_full;
   logic        fifo_empty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = !clk;

   h2c_wfifo u_h2c_wfifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_sel (master_sel),
      .fmt_master (fmt_master),
      .fmt_target (fmt_target),
      .host_valid (host_valid),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_ready (host_ready),
      .core_rd    (core_rd),
      .core_data  (core_data),
      .core_valid (core_valid),
      .fifo_full  (fifo_full),
      .fifo_empty (fifo_empty)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] a, input logic [31:0] d);
      host_valid = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic pop();
      core_rd = 1'b1;
      @(negedge clk);
      core_rd = 1'b0;
   endtask

   task automatic both(input logic [31:0] d);
      host_valid = 1'b1; host_addr = 16'h0000; host_wdata = d; core_rd = 1'b1;
      @(negedge clk);
      host_valid = 1'b0; core_rd = 1'b0;
   endtask

   task automatic set_mode(input logic m, input logic [1:0] fm, input logic [1:0] ft);
      master_sel = m; fmt_master = fm; fmt_target = ft;
      @(negedge clk);
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) pop();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 empty after reset", 32'(fifo_empty), 32'd1);
      chk("R10 valid after reset", 32'(core_valid), 32'd0);
      chk("R10 ready after reset", 32'(host_ready), 32'd1);
      chk("R10 full after reset", 32'(fifo_full), 32'd0);
   endtask

   task automatic t_narrow();
      set_mode(1'b1, 2'd1, 2'd0);
      for (int i = 0; i < 6; i++) begin
         chk("R1 not full before six", 32'(fifo_full), 32'd0);
         push(16'h0000, 32'hAA000000 + 32'(i * 'h010203)); // R5 address ignored
      end
      chk("R1 full at six", 32'(fifo_full), 32'd1);
      chk("R6 ready low when full", 32'(host_ready), 32'd0);
      push(16'h0100, 32'h77DEAD77);
      for (int i = 0; i < 6; i++) begin
         chk("R1 narrow order", 32'(core_data), (32'hAA000000 + 32'(i * 'h010203)) & 32'h00FFFFFF);
         pop();
      end
      chk("R6 dropped write not stored", 32'(fifo_empty), 32'd1);
   endtask

   task automatic t_wide_master();
      set_mode(1'b1, 2'd0, 2'd3); // R11 fmt_target ignored
      for (int i = 0; i < 3; i++) push(16'hFFFF, 32'h12345678 + 32'(i));
      chk("R2 wide full at three", 32'(fifo_full), 32'd1);
      chk("R5 master pushes any address", 32'(core_valid), 32'd1);
      for (int i = 0; i < 3; i++) begin
         chk("R3 low half first", 32'(core_data), 32'h00005678 + 32'(i));
         pop();
         chk("R3 entry kept after low half", 32'(fifo_full), (i == 0) ? 32'd1 : 32'd0);
         chk("R3 high half second", 32'(core_data), 32'h00001234);
         pop();
      end
      chk("R3 empty after six reads", 32'(fifo_empty), 32'd1);
   endtask

   task automatic t_target_window();
      set_mode(1'b0, 2'd1, 2'd0); // R11 fmt_master ignored, wide
      push(16'h0018, 32'h11111111);
      chk("R4 below window ignored", 32'(fifo_empty), 32'd1);
      push(16'hFFFD, 32'h22222222);
      chk("R4 above window ignored", 32'(fifo_empty), 32'd1);
      push(16'h001C, 32'hCAFEBABE);
      chk("R4 low bound accepted", 32'(core_data), 32'h0000BABE);
      push(16'hFFFC, 32'h33334444);
      push(16'h0200, 32'h55556666);
      chk("R11 target wide three deep", 32'(fifo_full), 32'd1);
   endtask

   task automatic t_mode_flush();
      set_mode(1'b0, 2'd1, 2'd2);
      chk("R9 flushed on mode change", 32'(fifo_empty), 32'd1);
      for (int i = 0; i < 4; i++) push(16'h0040, 32'h00ABC000 + 32'(i));
      chk("R2 target narrow holds more than three", 32'(fifo_full), 32'd0);
      chk("R2 target narrow data", 32'(core_data), 32'h00ABC000);
      set_mode(1'b1, 2'd0, 2'd2);
      push(16'h0000, 32'h9999AAAA);
      pop();
      chk("R9 high half pending", 32'(core_data), 32'h00009999);
      set_mode(1'b1, 2'd2, 2'd2);
      set_mode(1'b1, 2'd0, 2'd2);
      chk("R9 empty after two changes", 32'(fifo_empty), 32'd1);
      push(16'h0000, 32'hBBBBCCCC);
      chk("R9 half select back to low", 32'(core_data), 32'h0000CCCC);
      pop(); pop();
   endtask

   task automatic t_same_cycle();
      push(16'h0000, 32'hAAAA1111);
      pop();
      both(32'hBBBB2222);
      chk("R8 new word after finishing half", 32'(core_data), 32'h00002222);
      chk("R8 valid after same-cycle push/pop", 32'(core_valid), 32'd1);
      push(16'h0000, 32'h1);
      chk("R8 one entry plus one not full", 32'(fifo_full), 32'd0);
      push(16'h0000, 32'h2);
      chk("R8 full after two more", 32'(fifo_full), 32'd1);
      drain(6);
      chk("R8 drained", 32'(fifo_empty), 32'd1);
   endtask

   task automatic t_empty_read();
      set_mode(1'b1, 2'd1, 2'd0);
      pop();
      chk("R7 read on empty keeps empty", 32'(fifo_empty), 32'd1);
      both(32'h00456789);
      chk("R7 pop on empty ignored, push kept", 32'(core_data), 32'h00456789);
      chk("R7 valid after push", 32'(core_valid), 32'd1);
      pop();
      chk("R7 empty again", 32'(core_valid), 32'd0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_narrow();
      t_wide_master();
      t_target_window();
      t_mode_flush();
      t_same_cycle();
      t_empty_read();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule